// File: doc/BRIEF.md
# Transmit DMA Refill Controller

This controller feeds a transmit FIFO from a byte-addressed buffer memory. A one-cycle start pulse delivers a page number and a 16-bit length. The length arrives as two byte-wide fields, a low byte and a high byte. Reading begins at the first byte of that page, and the controller fetches one byte per read.

On a start, the controller first fills the FIFO to the brim. After that it holds off. It opens a new burst only when the FIFO occupancy sinks below a programmable threshold. A burst ends when the FIFO is full again or when the remaining length runs out.

The memory port has one cycle of read latency, and the FIFO write strobe lines up with the returned byte. When the last byte has been written, the controller raises a single-cycle done pulse and returns to idle.

Top module: `txdma_refill`

## Requirements
- R1: After reset, busy, done, mem_rd_en and fifo_wr_en are low and bytes_left is zero.
- R2: A start pulse seen while idle loads mem_addr with {page_start, 8'h00} and bytes_left with {count_hi, count_lo}, and raises busy, all visible in the following cycle.
- R3: fifo_wr_en is high exactly in the cycle after each cycle with mem_rd_en high, and fifo_wr_data carries the byte the memory returned for that read.
- R4: Each read advances mem_addr by one (wrapping at 16 bits) and lowers bytes_left by one.
- R5: From start until the FIFO first becomes full, a read is issued every cycle while bytes remain. No read is issued that would push occupancy above DEPTH.
- R6: Once the FIFO has been full, a new burst begins only after a cycle in which fifo_level plus any write in that cycle was below threshold.
- R7: Exactly the programmed number of bytes is read and written, and no read is issued once bytes_left is zero.
- R8: done is a one-cycle pulse in the cycle after the final FIFO write, with busy already low in that cycle.
- R9: A start with a length of zero issues no read, and pulses done in the cycle after the start.
- R10: A start pulse while busy has no effect on the address, the remaining count or the byte stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle transfer request |
| page_start | input | 8 | Page number of the first byte |
| count_lo | input | 8 | Length, low byte |
| count_hi | input | 8 | Length, high byte |
| threshold | input | LVL_W | Refill trigger level |
| fifo_level | input | LVL_W | Current FIFO occupancy |
| mem_rd_en | output | 1 | Memory read request |
| mem_addr | output | 16 | Memory byte address |
| mem_rd_data | input | 8 | Memory read data, one cycle after the request |
| fifo_wr_en | output | 1 | FIFO write strobe |
| fifo_wr_data | output | 8 | FIFO write data |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | Transfer complete pulse |
| bytes_left | output | 16 | Remaining byte count |

## Verification
The bench drains the FIFO at several rates, from every cycle down to every fifth cycle.

- **Full FIFO.** A controller that ignored the write still in flight would overfill the FIFO when it reaches full. A byte written twice or skipped would show up as a data mismatch against the address pattern.
- **Threshold.** An off-by-one in the threshold comparison would start refills one level early. The bench catches this with a threshold equal to depth and a threshold of one.
- **Length edge cases.** A zero length must never issue a read. A length of exactly the FIFO depth ends the transfer on the same cycle the FIFO fills, and the bench checks that it does not stall there. A length over 256 bytes, starting at page 0xFF, exercises the high count byte and address wrap.
- **Stray start.** A start pulse during a transfer must not reload anything. A reload would corrupt the byte stream or the total count.

// File: rtl/txdma_refill.sv
module txdma_refill #(
  parameter int DEPTH = 16,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [7:0]       page_start,
  input  logic [7:0]       count_lo,
  input  logic [7:0]       count_hi,
  input  logic [LVL_W-1:0] threshold,
  input  logic [LVL_W-1:0] fifo_level,
  output logic             mem_rd_en,
  output logic [15:0]      mem_addr,
  input  logic [7:0]       mem_rd_data,
  output logic             fifo_wr_en,
  output logic [7:0]       fifo_wr_data,
  output logic             busy,
  output logic             done,
  output logic [15:0]      bytes_left
);

  typedef enum logic [1:0] {S_IDLE, S_BURST, S_HOLD, S_LAST} st_t;

  st_t         st;
  logic        rvalid;
  logic [15:0] addr_q, remain_q;
  logic [LVL_W:0] proj;
  logic        room, low;

  assign proj  = {1'b0, fifo_level} + (LVL_W+1)'(rvalid);
  assign room  = proj < (LVL_W+1)'(DEPTH);
  assign low   = proj < {1'b0, threshold};

  assign mem_rd_en    = (st == S_BURST) && room;
  assign mem_addr     = addr_q;
  assign fifo_wr_en   = rvalid;
  assign fifo_wr_data = mem_rd_data;
  assign busy         = (st != S_IDLE);
  assign bytes_left   = remain_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      rvalid   <= 1'b0;
      addr_q   <= '0;
      remain_q <= '0;
      done     <= 1'b0;
    end else begin
      done   <= 1'b0;
      rvalid <= mem_rd_en;
      case (st)
        S_IDLE:
          if (start) begin
            addr_q   <= {page_start, 8'h00};
            remain_q <= {count_hi, count_lo};
            if ({count_hi, count_lo} == 16'd0) done <= 1'b1;
            else                               st   <= S_BURST;
          end
        S_BURST:
          if (room) begin
            addr_q   <= addr_q + 16'd1;
            remain_q <= remain_q - 16'd1;
            if (remain_q == 16'd1) st <= S_LAST;
          end else begin
            st <= S_HOLD;
          end
        S_HOLD:
          if (low) st <= S_BURST;
        S_LAST:
          if (rvalid) begin
            st   <= S_IDLE;
            done <= 1'b1;
          end
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/txdma_refill_chk.sv
module txdma_refill_chk #(
  parameter int DEPTH = 16,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic [7:0]       page_start,
  input logic [7:0]       count_lo,
  input logic [7:0]       count_hi,
  input logic [LVL_W-1:0] fifo_level,
  input logic             mem_rd_en,
  input logic [15:0]      mem_addr,
  input logic             fifo_wr_en,
  input logic             busy,
  input logic             done,
  input logic [15:0]      bytes_left
);

  AST_LOAD_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (mem_addr == {$past(page_start), 8'h00}) &&
                         (bytes_left == {$past(count_hi), $past(count_lo)})); // R2
  AST_RD_THEN_WR: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |=> fifo_wr_en); // R3
  AST_WR_HAS_RD: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_wr_en |-> $past(mem_rd_en)); // R3
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |=> mem_addr == $past(mem_addr) + 16'd1); // R4
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |=> bytes_left == $past(bytes_left) - 16'd1); // R4
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_level >= LVL_W'(DEPTH)) |-> !mem_rd_en); // R5
  AST_NO_RD_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bytes_left == 16'd0) |-> !mem_rd_en); // R7
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R8
  AST_IDLE_NO_RD: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_rd_en); // R9
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (start && busy && !mem_rd_en) |=> $stable(mem_addr) && $stable(bytes_left)); // R10

endmodule

bind txdma_refill txdma_refill_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .page_start(page_start),
  .count_lo(count_lo), .count_hi(count_hi), .fifo_level(fifo_level),
  .mem_rd_en(mem_rd_en), .mem_addr(mem_addr), .fifo_wr_en(fifo_wr_en),
  .busy(busy), .done(done), .bytes_left(bytes_left)
);

// File: tb/tb_txdma_refill.sv
`timescale 1ns/1ps
module tb_txdma_refill;
  localparam int DEPTH = 16;
  localparam int LVL_W = $clog2(DEPTH + 1);

  logic clk = 0, rst_n = 0, start = 0;
  logic [7:0] page_start = 0, count_lo = 0, count_hi = 0;
  logic [LVL_W-1:0] threshold = 0, fifo_level = 0;
  logic mem_rd_en, fifo_wr_en, busy, done;
  logic [15:0] mem_addr, bytes_left;
  logic [7:0] mem_rd_data = 0, fifo_wr_data;

  txdma_refill #(.DEPTH(DEPTH)) dut (.*);

  always #5 clk = ~clk;

  function automatic logic [7:0] mbyte(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction

  logic pop = 0;
  always @(posedge clk) begin
    if (mem_rd_en) mem_rd_data <= mbyte(mem_addr);
    if (!rst_n) fifo_level <= '0;
    else fifo_level <= fifo_level + LVL_W'(fifo_wr_en) - LVL_W'(pop);
  end

  int checks = 0, failures = 0, cyc = 0;
  int unsigned base = 0, exp_cnt = 0, nwr = 0, nrd = 0, derr = 0, maxlev = 0;
  int unsigned thr_bad = 0, gap_bad = 0, ndone = 0, div = 1, divc = 0;
  bit fill_done = 0, prev_rd = 0, rd_seen = 0;
  int unsigned prev_proj = 0;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      failures++;
      $display("FAIL watchdog: actual=%0d expected<=150000 cycles", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  always @(negedge clk) begin
    int unsigned proj;
    proj = fifo_level + fifo_wr_en;
    if (proj > maxlev) maxlev = proj;
    if (fifo_wr_en) begin
      if (fifo_wr_data != mbyte(16'(base + nwr))) derr++;
      nwr++;
    end
    if (mem_rd_en && !prev_rd && fill_done && !(prev_proj < threshold)) thr_bad++;
    if (rd_seen && !fill_done && !mem_rd_en && proj < DEPTH && exp_cnt > nrd) gap_bad++;
    if (mem_rd_en) begin nrd++; rd_seen = 1; end
    if (proj >= DEPTH) fill_done = 1;
    if (done) ndone++;
    prev_rd = mem_rd_en;
    prev_proj = proj;
    divc = (divc + 1) % div;
    pop <= (divc == 0) && (fifo_level != 0);
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk); #1;
  endtask

  task automatic arm(input logic [7:0] pg, input logic [15:0] cnt, input int thr, input int d);
    page_start = pg; count_lo = cnt[7:0]; count_hi = cnt[15:8];
    threshold = LVL_W'(thr); div = d;
    base = {pg, 8'h00}; exp_cnt = cnt;
    nwr = 0; nrd = 0; derr = 0; maxlev = 0; thr_bad = 0; gap_bad = 0; ndone = 0;
    fill_done = 0; prev_rd = 0; rd_seen = 0;
    start = 1; tick(); start = 0;
  endtask

  task automatic finish_case(input logic [15:0] cnt);
    int t = 0;
    while (ndone == 0 && t < 20000) begin tick(); t++; end
    chk(done == 1 && busy == 0, "R8 busy low in done cycle", busy, 0);
    tick(); tick(); tick();
    chk(ndone == 1, "R8 single done pulse", ndone, 1);
    chk(nwr == cnt && nrd == cnt, "R7 byte total", nwr, cnt);
    chk(bytes_left == 0, "R7 count exhausted", bytes_left, 0);
    chk(derr == 0, "R3 R4 data and address order", derr, 0);
    chk(maxlev <= DEPTH, "R5 no overflow", maxlev, DEPTH);
    chk(gap_bad == 0, "R5 fill continuous", gap_bad, 0);
    chk(thr_bad == 0, "R6 refill below threshold", thr_bad, 0);
  endtask

  localparam int NV = 6;
  localparam logic [39:0] VEC [NV] = '{
    {8'h10, 16'd40,  8'd4,  8'd3},
    {8'h22, 16'd100, 8'd8,  8'd2},
    {8'h05, 16'd10,  8'd4,  8'd4},
    {8'hFF, 16'd300, 8'd12, 8'd1},
    {8'h80, 16'd16,  8'd16, 8'd5},
    {8'h01, 16'd291, 8'd1,  8'd2}
  };

  initial begin
    repeat (3) tick();
    rst_n = 1;
    tick();
    chk(busy == 0 && done == 0, "R1 reset idle", busy, 0);
    chk(mem_rd_en == 0 && fifo_wr_en == 0, "R1 reset strobes", mem_rd_en, 0);
    chk(bytes_left == 0, "R1 reset count", bytes_left, 0);

    for (int i = 0; i < NV; i++) begin
      logic [39:0] v;
      v = VEC[i];
      arm(v[39:32], v[31:16], int'(v[15:8]), int'(v[7:0]));
      chk(bytes_left == v[31:16], "R2 count loaded", bytes_left, v[31:16]);
      chk(mem_addr == {v[39:32], 8'h00}, "R2 address loaded", mem_addr, {v[39:32], 8'h00});
      chk(busy == 1, "R2 busy raised", busy, 1);
      finish_case(v[31:16]);
    end

    arm(8'h44, 16'd0, 4, 2);
    chk(done == 1 && busy == 0, "R9 zero length done", done, 1);
    repeat (4) tick();
    chk(nrd == 0 && nwr == 0, "R9 zero length no read", nrd, 0);
    chk(ndone == 1, "R9 one pulse", ndone, 1);

    arm(8'h33, 16'd1, 4, 3);
    finish_case(16'd1);

    arm(8'h30, 16'd50, 6, 3);
    repeat (20) tick();
    page_start = 8'h70; count_lo = 8'd5; count_hi = 8'd0;
    start = 1; tick(); start = 0;
    chk(bytes_left != 16'd5 && mem_addr[15:8] != 8'h70, "R10 restart ignored", bytes_left, 5);
    finish_case(16'd50);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule